// File: doc/BRIEF.md
# Watchdog Interrupt Liveness Supervisor

This block sits behind a periodic watchdog timer and decides whether the supervised processing loop is still alive. The timer delivers a one-cycle expiry pulse roughly once a second. The supervised agent sends a one-cycle progress pulse each time its main loop completes. Every expiry is serviced at once: the block pulses clears for both stages of the timer's two-stage status. As a result, the timer's own second-expiry reset action can never trigger. That action is also reported as "none".

While supervision is enabled, the block counts expiries. On every third counted expiry it judges liveness. If at least one progress pulse arrived since the previous judgement, the progress count is cleared and the next window starts. If none arrived, the block raises a sticky halt request with a fixed watchdog-timeout code. Progress pulses are counted whether or not supervision is enabled. The count saturates, so a long burst of progress can never wrap to zero and look like a stall.

Top module: `wdt_liveness_sup`

## Requirements
- R1: Every expiry pulse, whether supervision is enabled or not, produces a one-cycle high on both `stat_clr_o` and `arm_clr_o` in the following cycle. Both outputs are low in every other cycle.
- R2: `rst_action_o` is always 2'b00, the code for "take no reset action".
- R3: The expiry count advances only on expiries seen while `sup_en_i` is high. Expiries seen while it is low leave the count unchanged.
- R4: The enabled expiry that brings the count to CHECK_EVERY (default 3) returns the count to zero and triggers a liveness judgement.
- R5: At a judgement, the window passes if the progress count is non-zero or a progress pulse arrives in the same cycle. The progress count is then zero from the next cycle, and the coincident pulse is not carried into the next window.
- R6: At a judgement with no progress, `halt_o` goes high in the next cycle and `halt_code_o` shows HALT_CODE (default 8'h0D).
- R7: Once high, `halt_o` stays high until reset, whatever the inputs. While `halt_o` is low, `halt_code_o` is zero.
- R8: The progress count saturates at 2^PROG_W-1. With PROG_W=8, a window of exactly 256 progress pulses passes the judgement.
- R9: Progress pulses are counted while `sup_en_i` is low.
- R10: While reset is asserted and after it is released, `halt_o`, `halt_code_o`, `stat_clr_o` and `arm_clr_o` are all zero and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sup_en_i | input | 1 | Supervision enable |
| expiry_i | input | 1 | One-cycle watchdog expiry pulse |
| progress_i | input | 1 | One-cycle loop-progress pulse from the supervised agent |
| stat_clr_o | output | 1 | Clear pulse for the interrupt-status stage of the timer |
| arm_clr_o | output | 1 | Clear pulse for the enable-next stage of the timer |
| rst_action_o | output | 2 | Timer reset action on a second unserviced expiry; always "none" |
| halt_o | output | 1 | Sticky halt request |
| halt_code_o | output | CODE_W | Halt reason code; zero when not halted |

## Verification
Two of the block's functions can fall in the same cycle: the liveness judgement at the third enabled expiry, and the arrival of a progress pulse. The bench makes them coincide by raising `progress_i` in the same cycle as that expiry, at a point where the progress count is zero. The judgement must pass (no halt). A further full window with no progress must then halt, which shows that the coincident pulse was consumed and not carried forward. The behavioural model in the bench applies the same rule on every clock and compares all outputs each cycle.

// File: rtl/wls_pkg.sv
package wls_pkg;
  typedef enum logic [1:0] {
    RST_NONE = 2'b00,
    RST_CORE = 2'b01,
    RST_CHIP = 2'b10,
    RST_SYS  = 2'b11
  } wdt_rst_action_e;

  localparam int unsigned DEF_CODE_W = 8;
  localparam logic [DEF_CODE_W-1:0] DEF_HALT_CODE = 8'h0D;
endpackage

// File: rtl/wls_flag_clear.sv
module wls_flag_clear (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expiry_i,
  output logic stat_clr_o,
  output logic arm_clr_o
);
  // serviced unconditionally so the timer never reaches its reset stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_clr_o <= 1'b0;
      arm_clr_o  <= 1'b0;
    end else begin
      stat_clr_o <= expiry_i;
      arm_clr_o  <= expiry_i;
    end
  end
endmodule

// File: rtl/wls_expiry_div.sv
module wls_expiry_div #(
  parameter int unsigned CHECK_EVERY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expiry_i,
  input  logic en_i,
  output logic check_o
);
  localparam int unsigned CNT_W = (CHECK_EVERY > 1) ? $clog2(CHECK_EVERY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHECK_EVERY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step    = expiry_i & en_i;
  assign check_o = step & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (check_o) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wls_progress_ctr.sv
module wls_progress_ctr #(
  parameter int unsigned PROG_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic progress_i,
  input  logic clear_i,
  output logic live_o
);
  localparam logic [PROG_W-1:0] SAT = {PROG_W{1'b1}};

  logic [PROG_W-1:0] cnt_q;

  // coincident pulse belongs to the window being judged
  assign live_o = (cnt_q != '0) | progress_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i)                   cnt_q <= '0;
    else if (progress_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_liveness_sup.sv
module wdt_liveness_sup
  import wls_pkg::*;
#(
  parameter int unsigned CHECK_EVERY = 3,
  parameter int unsigned PROG_W      = 8,
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter logic [CODE_W-1:0] HALT_CODE = CODE_W'(DEF_HALT_CODE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sup_en_i,
  input  logic              expiry_i,
  input  logic              progress_i,
  output logic              stat_clr_o,
  output logic              arm_clr_o,
  output logic [1:0]        rst_action_o,
  output logic              halt_o,
  output logic [CODE_W-1:0] halt_code_o
);
  logic check;
  logic live;
  logic halt_q;

  wls_flag_clear u_flag_clear (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expiry_i   (expiry_i),
    .stat_clr_o (stat_clr_o),
    .arm_clr_o  (arm_clr_o)
  );

  wls_expiry_div #(.CHECK_EVERY(CHECK_EVERY)) u_expiry_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expiry_i (expiry_i),
    .en_i     (sup_en_i),
    .check_o  (check)
  );

  wls_progress_ctr #(.PROG_W(PROG_W)) u_progress_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .progress_i (progress_i),
    .clear_i    (check),
    .live_o     (live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              halt_q <= 1'b0;
    else if (check && !live)  halt_q <= 1'b1;
  end

  assign rst_action_o = RST_NONE;
  assign halt_o       = halt_q;
  assign halt_code_o  = halt_q ? HALT_CODE : '0;
endmodule

// File: rtl/wdt_liveness_sup_chk.sv
module wdt_liveness_sup_chk #(
  parameter int unsigned CODE_W = 8,
  parameter logic [CODE_W-1:0] HALT_CODE = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sup_en_i,
  input logic              expiry_i,
  input logic              stat_clr_o,
  input logic              arm_clr_o,
  input logic              halt_o,
  input logic [CODE_W-1:0] halt_code_o
);
  a_r1_clear_after_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expiry_i |=> (stat_clr_o && arm_clr_o));

  a_r1_no_spurious_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expiry_i |=> (!stat_clr_o && !arm_clr_o));

  a_r6_halt_needs_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(expiry_i && sup_en_i));

  a_r6_code_when_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (halt_code_o == HALT_CODE));

  a_r7_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  a_r7_code_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_o |-> (halt_code_o == '0));
endmodule

bind wdt_liveness_sup wdt_liveness_sup_chk #(
  .CODE_W(CODE_W),
  .HALT_CODE(HALT_CODE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sup_en_i    (sup_en_i),
  .expiry_i    (expiry_i),
  .stat_clr_o  (stat_clr_o),
  .arm_clr_o   (arm_clr_o),
  .halt_o      (halt_o),
  .halt_code_o (halt_code_o)
);

// File: tb/wdt_liveness_sup_tb.sv
module wdt_liveness_sup_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sup_en = 1'b0;
  logic       expiry = 1'b0;
  logic       progress = 1'b0;
  logic       stat_clr, arm_clr, halt;
  logic [1:0] rst_action;
  logic [7:0] halt_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_exp = 0, m_prog = 0;
  bit m_halt = 0, m_clr = 0;

  always #4 clk = ~clk;

  wdt_liveness_sup u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sup_en_i(sup_en), .expiry_i(expiry),
    .progress_i(progress), .stat_clr_o(stat_clr), .arm_clr_o(arm_clr),
    .rst_action_o(rst_action), .halt_o(halt), .halt_code_o(halt_code)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_exp = 0; m_prog = 0; m_halt = 0; m_clr = 0;
    end else begin
      bit judge;
      m_clr = expiry;
      judge = expiry && sup_en && (m_exp == 2);
      if (judge) begin
        if (m_prog == 0 && !progress) m_halt = 1;
        m_prog = 0;
        m_exp = 0;
      end else begin
        if (progress && m_prog < 255) m_prog++;
        if (expiry && sup_en) m_exp++;
      end
    end
  end

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check_eq("R1 stat_clr", stat_clr, m_clr);
      check_eq("R1 arm_clr", arm_clr, m_clr);
      check_eq("R6/R7 halt", halt, m_halt);
      check_eq("R6/R7 code", halt_code, m_halt ? 8'h0D : 0);
      check_eq("R2 rst_action", rst_action, 0);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expire(bit en, bit prog = 0);
    sup_en = en; expiry = 1; progress = prog;
    tick();
    expiry = 0; progress = 0;
    tick(2);
  endtask

  task automatic pulse_progress(int n);
    for (int i = 0; i < n; i++) begin
      progress = 1; tick(); progress = 0; tick();
    end
  endtask

  task automatic do_reset();
    sup_en = 0; expiry = 0; progress = 0;
    rst_n = 0;
    tick(2);
    check_eq("R10 halt in reset", halt, 0);
    check_eq("R10 code in reset", halt_code, 0);
    check_eq("R10 clr in reset", stat_clr | arm_clr, 0);
    rst_n = 1;
    tick();
  endtask

  initial begin
    tick();
    do_reset();
    check_eq("R10 halt after reset", halt, 0);
    check_eq("R2 no reset action", rst_action, 0);

    // R4/R5: progress each window, no halt
    for (int w = 0; w < 3; w++) begin
      pulse_progress(1);
      expire(1); expire(1); expire(1);
    end
    check_eq("R5 live windows pass", halt, 0);

    // R5 clear then R6: window without progress halts
    expire(1); expire(1);
    check_eq("R4 no judgement before third", halt, 0);
    sup_en = 1; expiry = 1; tick(); expiry = 0;
    check_eq("R6 halt next cycle", halt, 1);
    check_eq("R6 halt code", halt_code, 8'h0D);
    tick(2);

    // R7: sticky under any input
    pulse_progress(3);
    expire(1); expire(0); expire(1, 1); expire(1);
    check_eq("R7 halt sticky", halt, 1);

    // R3: disabled expiries do not advance the count
    do_reset();
    expire(1); expire(1);
    for (int i = 0; i < 5; i++) expire(0);
    check_eq("R3 disabled expiries ignored", halt, 0);
    check_eq("R1 clears on disabled expiry", stat_clr, 0);
    expire(1);
    check_eq("R3 third enabled expiry judges", halt, 1);

    // R8: 256 pulses saturate, not wrap
    do_reset();
    pulse_progress(256);
    expire(1); expire(1); expire(1);
    check_eq("R8 saturated count passes", halt, 0);
    expire(1); expire(1); expire(1);
    check_eq("R8 cleared after pass", halt, 1);

    // R5: coincident progress at judgement
    do_reset();
    expire(1); expire(1); expire(1, 1);
    check_eq("R5 coincident progress passes", halt, 0);
    expire(1); expire(1); expire(1);
    check_eq("R5 coincident pulse not carried", halt, 1);

    // R9: progress counted while disabled
    do_reset();
    sup_en = 0;
    pulse_progress(1);
    expire(1); expire(1); expire(1);
    check_eq("R9 disabled progress counted", halt, 0);

    tick(3);
    done = 1;
  end

  initial begin
    wait (done || cycles > 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule